// File: doc/BRIEF.md
# Auto Power-Down Wake Controller

This block holds the power state of a peripheral whose host registers sit at offsets 0 to 7 of a small window. The peripheral goes into a low-power state when software writes a power-down command, or on its own when it has been idle for long enough and automatic power management is switched on. While it is down, the block gates the internal clock and switches off the output enables of every drive-side pin.

The block has two ways out of the low-power state. Any of the three reset sources wakes it: the external reset pin and two software reset bits held in separate control registers. A reset wake raises `core_reset`, so the rest of the peripheral runs its normal reset sequence. A host access to one of the two wake offsets also wakes it. This kind of wake does not raise `core_reset`, so register contents survive and operation picks up where it stopped. After an access wake, `ready` stays low for a fixed settling time. This models the clock source restarting before the peripheral accepts data again.

All pins are plain level or strobe signals. No data stream passes through the block, so no valid/ready handshake is involved. The host access strobe is sampled on every clock edge and is never back-pressured.

Top module: `pdw_ctrl`

## Requirements
- R1: Each reset source (`rst_pin` asynchronously, `sw_rst_dor` and `sw_rst_dsr` at the next clock edge) clears `pd_state` to 0, and `core_reset` is 1 while any of them is held.
- R2: A `pd_cmd` in a cycle where any reset source is active is ignored; `pd_state` is 0 after that edge.
- R3: With no reset active and `pd_state`=0, `pd_cmd`=1 sets `pd_state` to 1 at the next edge.
- R4: With `apm_en`=1 and `idle_limit`=N>0, `pd_state` becomes 1 at the edge that ends the N-th consecutive cycle with `idle`=1. A cycle with `idle`=0 restarts the count. `apm_en`=0 or `idle_limit`=0 disables automatic entry.
- R5: While `pd_state`=1, an access (`acc_valid`=1) with `acc_addr` equal to 4 or 5 clears `pd_state` at the next edge, and `clk_en` is 1 combinationally in that same cycle.
- R6: While `pd_state`=1, accesses with `acc_addr` in {0,1,2,3,6,7} leave `pd_state` at 1 and `clk_en` at 0.
- R7: An access wake never asserts `core_reset`.
- R8: Every bit of `drv_oe` is 0 while `pd_state`=1 and 1 while `pd_state`=0.
- R9: `clk_en` is 0 in every cycle with `pd_state`=1 and no wake event (no wake access, no reset).
- R10: `ready` is 0 while `pd_state`=1 or any reset is active. After an access wake it stays 0 for WAKE_DLY (default 4) cycles and then returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_pin | input | 1 | External reset pin, active high, asynchronous |
| sw_rst_dor | input | 1 | Software reset bit from the output control register, level |
| sw_rst_dsr | input | 1 | Software reset bit from the rate select register, level |
| pd_cmd | input | 1 | Power-down command bit write strobe |
| apm_en | input | 1 | Automatic power management enable |
| idle | input | 1 | Peripheral idle indication |
| idle_limit | input | CNT_W | Idle cycles before automatic entry; 0 disables |
| acc_valid | input | 1 | Decoded host register access strobe |
| acc_addr | input | ADDR_W | Register offset of the access |
| pd_state | output | 1 | 1 while powered down |
| drv_oe | output | NUM_DRV | Drive-side pin output enables |
| clk_en | output | 1 | Internal clock enable |
| ready | output | 1 | Peripheral may accept data |
| core_reset | output | 1 | Runs the normal reset sequence of the peripheral |

## Verification
The bound checker watches the cycle-level rules on every edge. These are reset clearing the state, command entry, wake and ignore on each access offset, pad enables following the state, clock gating during power-down, and `core_reset` staying low on an access wake. The bench scenarios alone cover the counted behaviours: the exact edge of automatic entry, the restart of the idle count, the disabled cases, and the length of the `ready` settling window after a wake.

// File: rtl/pdw_pkg.sv
package pdw_pkg;
  typedef enum logic {
    PW_RUN  = 1'b0,
    PW_DOWN = 1'b1
  } pw_state_e;
endpackage

// File: rtl/pdw_idle_timer.sv
// Counts consecutive idle cycles; flags the cycle that completes the limit.
module pdw_idle_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_pin,
  input  logic             clr,
  input  logic             apm_en,
  input  logic             idle,
  input  logic [CNT_W-1:0] idle_limit,
  output logic             idle_hit
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic             counting;
  logic [CNT_W:0]   seen;

  assign counting = apm_en && idle && !clr;
  assign seen     = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
  assign idle_hit = counting && (idle_limit != '0) && (seen >= {1'b0, idle_limit});

  always_ff @(posedge clk or posedge rst_pin) begin
    if (rst_pin) begin
      cnt_q <= '0;
    end else if (!counting) begin
      cnt_q <= '0;
    end else if (cnt_q != CNT_MAX) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/pdw_power_fsm.sv
// Power state, wake qualification and post-wake settling window.
module pdw_power_fsm
  import pdw_pkg::*;
#(
  parameter int ADDR_W   = 3,
  parameter int WAKE_DLY = 4,
  parameter int OFS_A    = 4,
  parameter int OFS_B    = 5
) (
  input  logic              clk,
  input  logic              rst_pin,
  input  logic              sw_rst,
  input  logic              rst_any,
  input  logic              pd_cmd,
  input  logic              idle_hit,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic              pd_state,
  output logic              wake_evt,
  output logic              ready
);
  localparam int DW = (WAKE_DLY < 1) ? 1 : $clog2(WAKE_DLY + 1);
  localparam logic [ADDR_W-1:0] WAKE_A = ADDR_W'(OFS_A);
  localparam logic [ADDR_W-1:0] WAKE_B = ADDR_W'(OFS_B);
  localparam logic [DW-1:0]     DLY_LD = DW'(WAKE_DLY);

  pw_state_e       state_q;
  logic [DW-1:0]   dly_q;
  logic            ofs_hit;
  logic            acc_wake;

  assign ofs_hit  = (acc_addr == WAKE_A) || (acc_addr == WAKE_B);
  assign acc_wake = (state_q == PW_DOWN) && acc_valid && ofs_hit;
  assign wake_evt = (state_q == PW_DOWN) && (acc_wake || rst_any);
  assign pd_state = (state_q == PW_DOWN);
  assign ready    = (state_q == PW_RUN) && !rst_any && (dly_q == '0);

  always_ff @(posedge clk or posedge rst_pin) begin
    if (rst_pin) begin
      state_q <= PW_RUN;
      dly_q   <= '0;
    end else if (sw_rst) begin
      state_q <= PW_RUN;
      dly_q   <= '0;
    end else begin
      case (state_q)
        PW_RUN: begin
          if (pd_cmd || idle_hit) begin
            state_q <= PW_DOWN;
            dly_q   <= '0;
          end else if (dly_q != '0) begin
            dly_q <= dly_q - 1'b1;
          end
        end
        default: begin
          if (acc_wake) begin
            state_q <= PW_RUN;
            dly_q   <= DLY_LD;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/pdw_pad_ctrl.sv
// Drive-side pin enables and clock gate derived from the power state.
module pdw_pad_ctrl #(
  parameter int NUM_DRV = 6
) (
  input  logic               pd_state,
  input  logic               wake_evt,
  output logic [NUM_DRV-1:0] drv_oe,
  output logic               clk_en
);
  for (genvar i = 0; i < NUM_DRV; i++) begin : g_pad
    assign drv_oe[i] = !pd_state;
  end

  assign clk_en = !pd_state || wake_evt;
endmodule

// File: rtl/pdw_ctrl.sv
module pdw_ctrl #(
  parameter int ADDR_W   = 3,
  parameter int CNT_W    = 16,
  parameter int NUM_DRV  = 6,
  parameter int WAKE_DLY = 4,
  parameter int OFS_A    = 4,
  parameter int OFS_B    = 5
) (
  input  logic               clk,
  input  logic               rst_pin,
  input  logic               sw_rst_dor,
  input  logic               sw_rst_dsr,
  input  logic               pd_cmd,
  input  logic               apm_en,
  input  logic               idle,
  input  logic [CNT_W-1:0]   idle_limit,
  input  logic               acc_valid,
  input  logic [ADDR_W-1:0]  acc_addr,
  output logic               pd_state,
  output logic [NUM_DRV-1:0] drv_oe,
  output logic               clk_en,
  output logic               ready,
  output logic               core_reset
);
  logic sw_rst;
  logic rst_any;
  logic idle_hit;
  logic wake_evt;

  assign sw_rst     = sw_rst_dor || sw_rst_dsr;
  assign rst_any    = rst_pin || sw_rst;
  assign core_reset = rst_any;

  pdw_idle_timer #(.CNT_W(CNT_W)) u_idle (
    .clk        (clk),
    .rst_pin    (rst_pin),
    .clr        (sw_rst || pd_state),
    .apm_en     (apm_en),
    .idle       (idle),
    .idle_limit (idle_limit),
    .idle_hit   (idle_hit)
  );

  pdw_power_fsm #(
    .ADDR_W   (ADDR_W),
    .WAKE_DLY (WAKE_DLY),
    .OFS_A    (OFS_A),
    .OFS_B    (OFS_B)
  ) u_fsm (
    .clk       (clk),
    .rst_pin   (rst_pin),
    .sw_rst    (sw_rst),
    .rst_any   (rst_any),
    .pd_cmd    (pd_cmd),
    .idle_hit  (idle_hit),
    .acc_valid (acc_valid),
    .acc_addr  (acc_addr),
    .pd_state  (pd_state),
    .wake_evt  (wake_evt),
    .ready     (ready)
  );

  pdw_pad_ctrl #(.NUM_DRV(NUM_DRV)) u_pad (
    .pd_state (pd_state),
    .wake_evt (wake_evt),
    .drv_oe   (drv_oe),
    .clk_en   (clk_en)
  );
endmodule

// File: rtl/pdw_ctrl_checker.sv
module pdw_ctrl_checker #(
  parameter int ADDR_W  = 3,
  parameter int NUM_DRV = 6,
  parameter int OFS_A   = 4,
  parameter int OFS_B   = 5
) (
  input logic               clk,
  input logic               rst_pin,
  input logic               sw_rst_dor,
  input logic               sw_rst_dsr,
  input logic               pd_cmd,
  input logic               acc_valid,
  input logic [ADDR_W-1:0]  acc_addr,
  input logic               pd_state,
  input logic [NUM_DRV-1:0] drv_oe,
  input logic               clk_en,
  input logic               ready,
  input logic               core_reset
);
  logic swr;
  logic wofs;
  assign swr  = sw_rst_dor || sw_rst_dsr;
  assign wofs = (acc_addr == ADDR_W'(OFS_A)) || (acc_addr == ADDR_W'(OFS_B));

  assert_rst_exit_R1: assert property (@(posedge clk) disable iff (rst_pin)
    swr |=> !pd_state);
  assert_rst_flag_R1: assert property (@(posedge clk) disable iff (rst_pin)
    swr |-> core_reset);
  assert_cmd_entry_R3: assert property (@(posedge clk) disable iff (rst_pin)
    (!pd_state && pd_cmd && !swr) |=> pd_state);
  assert_acc_wake_R5: assert property (@(posedge clk) disable iff (rst_pin)
    (pd_state && acc_valid && wofs) |-> clk_en);
  assert_acc_exit_R5: assert property (@(posedge clk) disable iff (rst_pin)
    (pd_state && acc_valid && wofs) |=> !pd_state);
  assert_ofs_ignored_R6: assert property (@(posedge clk) disable iff (rst_pin)
    (pd_state && acc_valid && !wofs && !swr) |=> pd_state);
  assert_quiet_wake_R7: assert property (@(posedge clk) disable iff (rst_pin)
    (pd_state && acc_valid && wofs && !swr) |-> !core_reset);
  assert_pads_off_R8: assert property (@(posedge clk) disable iff (rst_pin)
    pd_state |-> (drv_oe == '0));
  assert_pads_on_R8: assert property (@(posedge clk) disable iff (rst_pin)
    !pd_state |-> (&drv_oe));
  assert_clk_gated_R9: assert property (@(posedge clk) disable iff (rst_pin)
    (pd_state && !acc_valid && !swr) |-> !clk_en);
  assert_not_ready_R10: assert property (@(posedge clk) disable iff (rst_pin)
    (pd_state || swr) |-> !ready);
endmodule

bind pdw_ctrl pdw_ctrl_checker #(
  .ADDR_W  (ADDR_W),
  .NUM_DRV (NUM_DRV),
  .OFS_A   (OFS_A),
  .OFS_B   (OFS_B)
) u_chk (
  .clk        (clk),
  .rst_pin    (rst_pin),
  .sw_rst_dor (sw_rst_dor),
  .sw_rst_dsr (sw_rst_dsr),
  .pd_cmd     (pd_cmd),
  .acc_valid  (acc_valid),
  .acc_addr   (acc_addr),
  .pd_state   (pd_state),
  .drv_oe     (drv_oe),
  .clk_en     (clk_en),
  .ready      (ready),
  .core_reset (core_reset)
);

// File: tb/pdw_ctrl_test.sv
`timescale 1ns/1ps
module pdw_ctrl_test;
  localparam int ADDR_W   = 3;
  localparam int CNT_W    = 16;
  localparam int NUM_DRV  = 6;
  localparam int WAKE_DLY = 4;

  logic               clk = 1'b0;
  logic               rst_pin = 1'b1;
  logic               sw_rst_dor = 1'b0;
  logic               sw_rst_dsr = 1'b0;
  logic               pd_cmd = 1'b0;
  logic               apm_en = 1'b0;
  logic               idle = 1'b0;
  logic [CNT_W-1:0]   idle_limit = 16'd5;
  logic               acc_valid = 1'b0;
  logic [ADDR_W-1:0]  acc_addr = '0;
  logic               pd_state;
  logic [NUM_DRV-1:0] drv_oe;
  logic               clk_en;
  logic               ready;
  logic               core_reset;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pdw_ctrl #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .NUM_DRV(NUM_DRV), .WAKE_DLY(WAKE_DLY),
    .OFS_A(4), .OFS_B(5)
  ) uut (
    .clk(clk), .rst_pin(rst_pin), .sw_rst_dor(sw_rst_dor), .sw_rst_dsr(sw_rst_dsr),
    .pd_cmd(pd_cmd), .apm_en(apm_en), .idle(idle), .idle_limit(idle_limit),
    .acc_valid(acc_valid), .acc_addr(acc_addr), .pd_state(pd_state),
    .drv_oe(drv_oe), .clk_en(clk_en), .ready(ready), .core_reset(core_reset)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // Put the block into power-down with the command bit (R3, R8, R9)
  task automatic t_cmd_entry();
    pd_cmd = 1'b1;
    tick();
    pd_cmd = 1'b0;
    chk("R3", "pd_state after cmd", 32'(pd_state), 1);
    chk("R8", "drv_oe while down", 32'(drv_oe), 0);
    chk("R9", "clk_en while down", 32'(clk_en), 0);
    chk("R10", "ready while down", 32'(ready), 0);
  endtask

  task automatic t_reset_state();
    chk("R1", "core_reset during pin reset", 32'(core_reset), 1);
    chk("R1", "pd_state in reset", 32'(pd_state), 0);
    chk("R8", "drv_oe in reset", 32'(drv_oe), 32'(6'h3f));
    chk("R10", "ready in reset", 32'(ready), 0);
    rst_pin = 1'b0;
    #1;
    chk("R1", "core_reset released", 32'(core_reset), 0);
    chk("R10", "ready after reset", 32'(ready), 1);
    tick();
  endtask

  task automatic t_ignored_offsets();
    for (int a = 0; a < 8; a++) begin
      if (a == 4 || a == 5) continue;
      acc_valid = 1'b1;
      acc_addr  = 3'(a);
      #1;
      chk("R6", $sformatf("clk_en during ofs %0d", a), 32'(clk_en), 0);
      tick();
      acc_valid = 1'b0;
      chk("R6", $sformatf("pd_state after ofs %0d", a), 32'(pd_state), 1);
    end
  endtask

  task automatic t_access_wake(input logic [2:0] ofs);
    acc_valid = 1'b1;
    acc_addr  = ofs;
    #1;
    chk("R5", $sformatf("clk_en in wake cycle ofs %0d", ofs), 32'(clk_en), 1);
    chk("R7", "core_reset during access wake", 32'(core_reset), 0);
    tick();
    acc_valid = 1'b0;
    chk("R5", "pd_state after wake", 32'(pd_state), 0);
    chk("R7", "core_reset after wake", 32'(core_reset), 0);
    chk("R8", "drv_oe after wake", 32'(drv_oe), 32'(6'h3f));
    chk("R10", "ready right after wake", 32'(ready), 0);
    for (int i = 1; i < WAKE_DLY; i++) begin
      tick();
      chk("R10", $sformatf("ready %0d cycles after wake", i), 32'(ready), 0);
    end
    tick();
    chk("R10", "ready after settling", 32'(ready), 1);
  endtask

  task automatic t_reset_wakes();
    t_cmd_entry();
    sw_rst_dor = 1'b1;
    #1;
    chk("R1", "core_reset on dor bit", 32'(core_reset), 1);
    tick();
    sw_rst_dor = 1'b0;
    chk("R1", "pd_state after dor reset", 32'(pd_state), 0);
    t_cmd_entry();
    sw_rst_dsr = 1'b1;
    #1;
    chk("R1", "core_reset on dsr bit", 32'(core_reset), 1);
    tick();
    sw_rst_dsr = 1'b0;
    chk("R1", "pd_state after dsr reset", 32'(pd_state), 0);
    t_cmd_entry();
    rst_pin = 1'b1;
    #1;
    chk("R1", "pd_state under pin reset", 32'(pd_state), 0);
    tick();
    rst_pin = 1'b0;
    tick();
  endtask

  task automatic t_reset_priority();
    sw_rst_dsr = 1'b1;
    pd_cmd     = 1'b1;
    tick();
    sw_rst_dsr = 1'b0;
    pd_cmd     = 1'b0;
    chk("R2", "pd_cmd during reset ignored", 32'(pd_state), 0);
    tick();
    chk("R2", "still running later", 32'(pd_state), 0);
  endtask

  task automatic t_auto_entry();
    idle_limit = 16'd5;
    apm_en = 1'b1;
    idle   = 1'b1;
    repeat (4) tick();
    chk("R4", "not down after 4 idle cycles", 32'(pd_state), 0);
    tick();
    chk("R4", "down after 5 idle cycles", 32'(pd_state), 1);
    idle = 1'b0;
    t_access_wake(3'd5);
    idle = 1'b1;
    repeat (3) tick();
    idle = 1'b0;
    tick();
    idle = 1'b1;
    repeat (4) tick();
    chk("R4", "count restarted by idle gap", 32'(pd_state), 0);
    tick();
    chk("R4", "down after fresh 5 cycles", 32'(pd_state), 1);
    idle = 1'b0;
    t_access_wake(3'd4);
    apm_en = 1'b0;
    idle   = 1'b1;
    repeat (10) tick();
    chk("R4", "apm_en=0 blocks entry", 32'(pd_state), 0);
    apm_en = 1'b1;
    idle_limit = '0;
    repeat (10) tick();
    chk("R4", "limit 0 blocks entry", 32'(pd_state), 0);
    idle = 1'b0;
    apm_en = 1'b0;
    idle_limit = 16'd5;
    tick();
  endtask

  initial begin
    repeat (3) tick();
    t_reset_state();
    t_cmd_entry();
    t_ignored_offsets();
    t_access_wake(3'd4);
    t_cmd_entry();
    t_access_wake(3'd5);
    t_reset_wakes();
    t_reset_priority();
    t_auto_entry();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule